// File: doc/BRIEF.md
# NAND ECC Engine Register Block

This block is the software-visible control face of a NAND error-correction engine. A simple 32-bit bus with single-cycle write and read strobes reaches the engine configuration (enable and correction-strength index), the host-side transfer configuration, the chunk count, the two DMA base addresses, a DMA command register and a fixed version word. The datapath itself lives elsewhere: it sees the stored fields on dedicated outputs and gets a one-cycle launch pulse when software commands a transfer.

The datapath reports six kinds of event on single-cycle inputs. Each event is latched into a sticky status bit, but only when software has enabled that bit in a status-enable mask. A second mask decides which latched bits raise the single interrupt line. Software clears latched bits by writing ones to the status word, so writing back the value it just read is a clean acknowledge. A launch command is honoured only while the engine enable bit is set.

Top module: `ecc_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, the interrupt line is 0 and no launch pulse is produced.
- R2: The configuration word at offset 0x00 stores the engine enable in bit 0 and a 4-bit correction index in bits 6:3; all other bits read 0.
- R3: Event inputs map to status bits 0 to 5 as transfer done, main DMA, spare DMA, ECC error, to-spare, to-main; an event sets its status bit at offset 0x04 only when the same bit of the status-enable mask (offset 0x08) is 1, and the bit then stays set.
- R4: A write to offset 0x04 clears each status bit written as 1 and leaves every bit written as 0 unchanged.
- R5: When an enabled event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: The interrupt output is 1 exactly when some status bit and the same bit of the signal-enable mask (offset 0x0C) are both 1.
- R7: Writing offset 0x40 with bit 31 set while the engine is enabled gives a launch pulse high for exactly the one cycle after the write; bit 1 (1 = read from NAND) and the continuation flags in bits 29 and 30 are stored and read back, while bit 31 reads 0 once the pulse has passed.
- R8: A write with bit 31 set to offset 0x40 while the engine enable bit is 0 produces no launch pulse.
- R9: The host configuration at offset 0x10 stores incrementing burst (bit 0), interleaved layout (bit 2), memory-to-memory mode (bit 4) and mapping mode (bit 5), drives them on outputs, and reads every other bit as 0.
- R10: Chunk count (0x30, CNT_W bits), main address (0x44) and spare address (0x48) read back as written; offset 0xD0 returns the VERSION parameter in bits 31:16 and 0 below; any unmapped offset reads 0.
- R11: Read data is registered: it carries the addressed value in the cycle after the read strobe and is 0 in any cycle not following a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per access |
| bus_rd_en | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_i | input | 6 | Datapath event pulses, one per status bit |
| irq_o | output | 1 | Interrupt line |
| xfer_start_o | output | 1 | One-cycle transfer launch pulse |
| xfer_read_o | output | 1 | Stored transfer direction, 1 = read from NAND |
| cont_nand_o | output | 1 | Stored NAND-side continuation flag |
| cont_sysm_o | output | 1 | Stored memory-side continuation flag |
| eng_enable_o | output | 1 | Engine enable |
| ecc_type_o | output | 4 | Correction-strength index |
| burst_incr_o | output | 1 | Incrementing burst select |
| layout_interleave_o | output | 1 | Interleaved layout select |
| mode_mem2mem_o | output | 1 | Memory-to-memory mode select |
| mode_mapping_o | output | 1 | Mapping mode select |
| chunk_count_o | output | CNT_W (8) | Chunk count |
| main_addr_o | output | DMA_AW (32) | Main-data DMA address |
| spare_addr_o | output | DMA_AW (32) | Spare-data DMA address |

## Verification
Every stored field, status bit and the interrupt line change at the clock edge that samples the write strobe or event, so the bench looks at them at the falling edge that follows that edge. The launch pulse is high during the first full cycle after the accepted write and low in the next, and the bench samples both of those cycles. Read data arrives one edge after the read strobe: the driver queues the expected word when it raises the strobe and the monitor pops and compares it at the falling edge after the capture edge, with an idle cycle checked for zero.

// File: rtl/ecc_regs_pkg.sv
// Package: shared offsets, bit positions and widths for the ECC register
// block. Assumes byte offsets on a 32-bit word bus.
package ecc_regs_pkg;

    localparam int NUM_EVT  = 6;
    localparam int TYPE_W   = 4;

    // register offsets (driver software depends on these)
    localparam logic [7:0] OFF_CFG    = 8'h00;
    localparam logic [7:0] OFF_STS    = 8'h04;
    localparam logic [7:0] OFF_STS_EN = 8'h08;
    localparam logic [7:0] OFF_SIG_EN = 8'h0C;
    localparam logic [7:0] OFF_HOST   = 8'h10;
    localparam logic [7:0] OFF_CHUNK  = 8'h30;
    localparam logic [7:0] OFF_DMA    = 8'h40;
    localparam logic [7:0] OFF_MAIN   = 8'h44;
    localparam logic [7:0] OFF_SPARE  = 8'h48;
    localparam logic [7:0] OFF_VER    = 8'hD0;

    // configuration word fields
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_TYPE_LSB = 3;

    // host configuration bits
    localparam int HOST_BURST_BIT = 0;
    localparam int HOST_ILV_BIT   = 2;
    localparam int HOST_M2M_BIT   = 4;
    localparam int HOST_MAP_BIT   = 5;

    // DMA command bits
    localparam int DMA_DIR_BIT   = 1;
    localparam int DMA_CNAND_BIT = 29;
    localparam int DMA_CSYS_BIT  = 30;
    localparam int DMA_GO_BIT    = 31;

    localparam int VER_LSB = 16;

    typedef struct packed {
        logic mapping;
        logic mem2mem;
        logic interleave;
        logic burst_incr;
    } host_cfg_t;

endpackage

// File: rtl/ecc_irq_status.sv
// Module: sticky event status with a latch-enable mask and an interrupt
// signal-enable mask. Assumes events are single-cycle pulses and that the
// clear strobe carries write-one-to-clear data.
module ecc_irq_status #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         wr_clr_i,
    input  logic         wr_sts_en_i,
    input  logic         wr_sig_en_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] sts_o,
    output logic [N-1:0] sts_en_o,
    output logic [N-1:0] sig_en_o,
    output logic         irq_o
);

    logic [N-1:0] sts_q;
    logic [N-1:0] sts_en_q;
    logic [N-1:0] sig_en_q;
    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;
    logic [N-1:0] sts_d;

    // per-bit next state: an enabled event beats a clear on the same bit
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign set_v[i] = evt_i[i] & sts_en_q[i];
        assign clr_v[i] = wr_clr_i & wdata_i[i];
        always_comb begin
            if (set_v[i])      sts_d[i] = 1'b1;
            else if (clr_v[i]) sts_d[i] = 1'b0;
            else               sts_d[i] = sts_q[i];
        end
    end

    // latched status bits
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    // status-enable and signal-enable masks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_en_q <= '0;
            sig_en_q <= '0;
        end else begin
            if (wr_sts_en_i) sts_en_q <= wdata_i;
            if (wr_sig_en_i) sig_en_q <= wdata_i;
        end
    end

    assign irq_o    = |(sts_q & sig_en_q);
    assign sts_o    = sts_q;
    assign sts_en_o = sts_en_q;
    assign sig_en_o = sig_en_q;

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & ~$past(sts_q) & ~$past(evt_i & sts_en_q)) == '0)); // R3
    AST_CLEAR_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sts_q) & ~sts_q & ~($past(wdata_i) & {N{$past(wr_clr_i)}})) == '0)); // R4
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & $past(evt_i & sts_en_q)) == $past(evt_i & sts_en_q))); // R5
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (sts_q != '0) && (sig_en_q != '0)); // R6

endmodule

// File: rtl/ecc_xfer_ctrl.sv
// Module: DMA command register. Holds direction and continuation flags and
// turns a go bit into a one-cycle launch pulse, gated by the engine enable.
// Assumes the enable input is the stored configuration bit.
module ecc_xfer_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        go_i,
    input  logic        dir_i,
    input  logic        cnand_i,
    input  logic        csys_i,
    input  logic        enable_i,
    output logic        start_o,
    output logic        read_o,
    output logic        cont_nand_o,
    output logic        cont_sysm_o,
    output logic [31:0] readback_o
);
    import ecc_regs_pkg::*;

    logic start_q;
    logic dir_q;
    logic cnand_q;
    logic csys_q;

    // launch pulse: only on an accepted go write, cleared the next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= wr_i & go_i & enable_i;
    end

    // stored direction and continuation flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            cnand_q <= 1'b0;
            csys_q  <= 1'b0;
        end else if (wr_i) begin
            dir_q   <= dir_i;
            cnand_q <= cnand_i;
            csys_q  <= csys_i;
        end
    end

    // readback word assembly
    always_comb begin
        readback_o                = '0;
        readback_o[DMA_GO_BIT]    = start_q;
        readback_o[DMA_CSYS_BIT]  = csys_q;
        readback_o[DMA_CNAND_BIT] = cnand_q;
        readback_o[DMA_DIR_BIT]   = dir_q;
    end

    assign start_o     = start_q;
    assign read_o      = dir_q;
    assign cont_nand_o = cnand_q;
    assign cont_sysm_o = csys_q;

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R7
    AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> $past(enable_i) && $past(wr_i)); // R8

endmodule

// File: rtl/ecc_cfg_regs.sv
// Module: plain configuration storage (engine config, host config, chunk
// count, DMA addresses) plus the registered read multiplexer for the whole
// block. Assumes write strobes are already decoded by the top.
module ecc_cfg_regs #(
    parameter int          AW      = 8,
    parameter int          CNT_W   = 8,
    parameter int          DMA_AW  = 32,
    parameter int          N       = 6,
    parameter logic [15:0] VERSION = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cfg_i,
    input  logic              wr_host_i,
    input  logic              wr_chunk_i,
    input  logic              wr_main_i,
    input  logic              wr_spare_i,
    input  logic [31:0]       wdata_i,
    input  logic              rd_en_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [N-1:0]      sts_i,
    input  logic [N-1:0]      sts_en_i,
    input  logic [N-1:0]      sig_en_i,
    input  logic [31:0]       xfer_rb_i,
    output logic              enable_o,
    output logic [3:0]        type_o,
    output ecc_regs_pkg::host_cfg_t host_o,
    output logic [CNT_W-1:0]  chunk_o,
    output logic [DMA_AW-1:0] main_o,
    output logic [DMA_AW-1:0] spare_o,
    output logic [31:0]       rdata_o
);
    import ecc_regs_pkg::*;

    localparam int TYPE_MSB = CFG_TYPE_LSB + TYPE_W - 1;

    logic              en_q;
    logic [3:0]        type_q;
    host_cfg_t         host_q;
    logic [CNT_W-1:0]  chunk_q;
    logic [DMA_AW-1:0] main_q;
    logic [DMA_AW-1:0] spare_q;
    logic [31:0]       rd_mux;
    logic [31:0]       rdata_q;

    // engine configuration word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            type_q <= '0;
        end else if (wr_cfg_i) begin
            en_q   <= wdata_i[CFG_EN_BIT];
            type_q <= wdata_i[TYPE_MSB:CFG_TYPE_LSB];
        end
    end

    // host transfer configuration
    always_ff @(posedge clk) begin
        if (!rst_n) host_q <= '0;
        else if (wr_host_i) begin
            host_q.burst_incr <= wdata_i[HOST_BURST_BIT];
            host_q.interleave <= wdata_i[HOST_ILV_BIT];
            host_q.mem2mem    <= wdata_i[HOST_M2M_BIT];
            host_q.mapping    <= wdata_i[HOST_MAP_BIT];
        end
    end

    // chunk count and DMA base addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chunk_q <= '0;
            main_q  <= '0;
            spare_q <= '0;
        end else begin
            if (wr_chunk_i) chunk_q <= wdata_i[CNT_W-1:0];
            if (wr_main_i)  main_q  <= wdata_i[DMA_AW-1:0];
            if (wr_spare_i) spare_q <= wdata_i[DMA_AW-1:0];
        end
    end

    // read multiplexer by offset
    always_comb begin
        rd_mux = '0;
        case (addr_i)
            AW'(OFF_CFG): begin
                rd_mux[CFG_EN_BIT]               = en_q;
                rd_mux[TYPE_MSB:CFG_TYPE_LSB]    = type_q;
            end
            AW'(OFF_STS):    rd_mux[N-1:0] = sts_i;
            AW'(OFF_STS_EN): rd_mux[N-1:0] = sts_en_i;
            AW'(OFF_SIG_EN): rd_mux[N-1:0] = sig_en_i;
            AW'(OFF_HOST): begin
                rd_mux[HOST_BURST_BIT] = host_q.burst_incr;
                rd_mux[HOST_ILV_BIT]   = host_q.interleave;
                rd_mux[HOST_M2M_BIT]   = host_q.mem2mem;
                rd_mux[HOST_MAP_BIT]   = host_q.mapping;
            end
            AW'(OFF_CHUNK):  rd_mux[CNT_W-1:0]  = chunk_q;
            AW'(OFF_DMA):    rd_mux             = xfer_rb_i;
            AW'(OFF_MAIN):   rd_mux[DMA_AW-1:0] = main_q;
            AW'(OFF_SPARE):  rd_mux[DMA_AW-1:0] = spare_q;
            AW'(OFF_VER):    rd_mux[31:VER_LSB] = VERSION;
            default:         rd_mux = '0;
        endcase
    end

    // registered read data, zero outside read responses
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_en_i) rdata_q <= rd_mux;
        else              rdata_q <= '0;
    end

    assign enable_o = en_q;
    assign type_o   = type_q;
    assign host_o   = host_q;
    assign chunk_o  = chunk_q;
    assign main_o   = main_q;
    assign spare_o  = spare_q;
    assign rdata_o  = rdata_q;

    AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en_i) |-> rdata_o == '0); // R11
    AST_CFG_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en_i) && $past(addr_i) == AW'(OFF_CFG) |-> rdata_o[31:7] == '0); // R2

endmodule

// File: rtl/ecc_ctrl_regs.sv
// Module: top of the ECC engine register block. Decodes single-cycle bus
// writes into per-register strobes and wires the status, transfer-command
// and configuration units together. Assumes at most one access per cycle.
module ecc_ctrl_regs #(
    parameter int          AW      = 8,
    parameter int          CNT_W   = 8,
    parameter int          DMA_AW  = 32,
    parameter logic [15:0] VERSION = 16'h0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        evt_i,
    output logic              irq_o,
    output logic              xfer_start_o,
    output logic              xfer_read_o,
    output logic              cont_nand_o,
    output logic              cont_sysm_o,
    output logic              eng_enable_o,
    output logic [3:0]        ecc_type_o,
    output logic              burst_incr_o,
    output logic              layout_interleave_o,
    output logic              mode_mem2mem_o,
    output logic              mode_mapping_o,
    output logic [CNT_W-1:0]  chunk_count_o,
    output logic [DMA_AW-1:0] main_addr_o,
    output logic [DMA_AW-1:0] spare_addr_o
);
    import ecc_regs_pkg::*;

    logic           wr_cfg, wr_sts, wr_sts_en, wr_sig_en, wr_host;
    logic           wr_chunk, wr_dma, wr_main, wr_spare;
    logic [NUM_EVT-1:0] sts, sts_en, sig_en;
    logic [31:0]    xfer_rb;
    logic           enable;
    host_cfg_t      host;

    // write strobe decode by offset
    always_comb begin
        wr_cfg    = bus_wr_en && (bus_addr == AW'(OFF_CFG));
        wr_sts    = bus_wr_en && (bus_addr == AW'(OFF_STS));
        wr_sts_en = bus_wr_en && (bus_addr == AW'(OFF_STS_EN));
        wr_sig_en = bus_wr_en && (bus_addr == AW'(OFF_SIG_EN));
        wr_host   = bus_wr_en && (bus_addr == AW'(OFF_HOST));
        wr_chunk  = bus_wr_en && (bus_addr == AW'(OFF_CHUNK));
        wr_dma    = bus_wr_en && (bus_addr == AW'(OFF_DMA));
        wr_main   = bus_wr_en && (bus_addr == AW'(OFF_MAIN));
        wr_spare  = bus_wr_en && (bus_addr == AW'(OFF_SPARE));
    end

    ecc_irq_status #(.N(NUM_EVT)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .wr_clr_i    (wr_sts),
        .wr_sts_en_i (wr_sts_en),
        .wr_sig_en_i (wr_sig_en),
        .wdata_i     (bus_wdata[NUM_EVT-1:0]),
        .sts_o       (sts),
        .sts_en_o    (sts_en),
        .sig_en_o    (sig_en),
        .irq_o       (irq_o)
    );

    ecc_xfer_ctrl u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (wr_dma),
        .go_i        (bus_wdata[DMA_GO_BIT]),
        .dir_i       (bus_wdata[DMA_DIR_BIT]),
        .cnand_i     (bus_wdata[DMA_CNAND_BIT]),
        .csys_i      (bus_wdata[DMA_CSYS_BIT]),
        .enable_i    (enable),
        .start_o     (xfer_start_o),
        .read_o      (xfer_read_o),
        .cont_nand_o (cont_nand_o),
        .cont_sysm_o (cont_sysm_o),
        .readback_o  (xfer_rb)
    );

    ecc_cfg_regs #(
        .AW(AW), .CNT_W(CNT_W), .DMA_AW(DMA_AW), .N(NUM_EVT), .VERSION(VERSION)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cfg_i   (wr_cfg),
        .wr_host_i  (wr_host),
        .wr_chunk_i (wr_chunk),
        .wr_main_i  (wr_main),
        .wr_spare_i (wr_spare),
        .wdata_i    (bus_wdata),
        .rd_en_i    (bus_rd_en),
        .addr_i     (bus_addr),
        .sts_i      (sts),
        .sts_en_i   (sts_en),
        .sig_en_i   (sig_en),
        .xfer_rb_i  (xfer_rb),
        .enable_o   (enable),
        .type_o     (ecc_type_o),
        .host_o     (host),
        .chunk_o    (chunk_count_o),
        .main_o     (main_addr_o),
        .spare_o    (spare_addr_o),
        .rdata_o    (bus_rdata)
    );

    assign eng_enable_o        = enable;
    assign burst_incr_o        = host.burst_incr;
    assign layout_interleave_o = host.interleave;
    assign mode_mem2mem_o      = host.mem2mem;
    assign mode_mapping_o      = host.mapping;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq_o && !xfer_start_o && bus_rdata == '0); // R1
    AST_IRQ_CLEAR_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_en == '0) |-> !irq_o); // R6

endmodule

// File: tb/sim_ecc_ctrl_regs.sv
// Bench: scoreboard style. Read tasks queue the expected word; a monitor
// pops and compares at the falling edge after the capture edge.
module sim_ecc_ctrl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  evt_i = '0;
    logic        irq_o, xfer_start_o, xfer_read_o, cont_nand_o, cont_sysm_o;
    logic        eng_enable_o, burst_incr_o, layout_interleave_o;
    logic        mode_mem2mem_o, mode_mapping_o;
    logic [3:0]  ecc_type_o;
    logic [7:0]  chunk_count_o;
    logic [31:0] main_addr_o, spare_addr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk; // 50 MHz

    ecc_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_i(evt_i), .irq_o(irq_o), .xfer_start_o(xfer_start_o),
        .xfer_read_o(xfer_read_o), .cont_nand_o(cont_nand_o),
        .cont_sysm_o(cont_sysm_o), .eng_enable_o(eng_enable_o),
        .ecc_type_o(ecc_type_o), .burst_incr_o(burst_incr_o),
        .layout_interleave_o(layout_interleave_o),
        .mode_mem2mem_o(mode_mem2mem_o), .mode_mapping_o(mode_mapping_o),
        .chunk_count_o(chunk_count_o), .main_addr_o(main_addr_o),
        .spare_addr_o(spare_addr_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        @(negedge clk);
        evt_i = e;
        @(negedge clk);
        evt_i = '0;
    endtask

    // track which cycles carry a read response
    always @(posedge clk) rd_d <= bus_rd_en;

    // monitor: compare read responses against the queue, idle cycles against 0
    always @(negedge clk) begin
        if (rst_n && rd_d) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 actual=0x%08h expected=<no queued read>", bus_rdata);
            end else begin
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values seen while reset held and after release
        check({31'b0, irq_o}, 0, "R1 irq in reset");
        check(bus_rdata, 0, "R1 rdata in reset");
        rst_n = 1'b1;
        check({31'b0, xfer_start_o}, 0, "R1 start after reset");
        rd(8'h00, 32'h0, "R1 cfg reset");
        rd(8'h04, 32'h0, "R1 status reset");
        rd(8'h40, 32'h0, "R1 dma reset");
        rd(8'h44, 32'h0, "R1 main addr reset");

        // R11: idle cycle after a read returns zero
        @(negedge clk);
        check(bus_rdata, 0, "R11 idle rdata");

        // R2: configuration fields
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0000_0079, "R2 cfg all ones");
        check({27'b0, eng_enable_o, ecc_type_o}, 32'h1F, "R2 cfg outputs");
        wr(8'h00, 32'h0000_0011);
        rd(8'h00, 32'h0000_0011, "R2 cfg idx2 enabled");

        // R3: event latching gated by the status-enable mask
        wr(8'h08, 32'h0000_0005);
        rd(8'h08, 32'h0000_0005, "R3 status enable readback");
        pulse_evt(6'h3F);
        rd(8'h04, 32'h0000_0005, "R3 gated latch");
        check({31'b0, irq_o}, 0, "R6 no signal enable");
        @(negedge clk);
        rd(8'h04, 32'h0000_0005, "R3 sticky");

        // R6: interrupt line follows status AND signal-enable
        wr(8'h0C, 32'h0000_0004);
        check({31'b0, irq_o}, 1, "R6 irq raised");
        rd(8'h0C, 32'h0000_0004, "R6 signal enable readback");

        // R4: write-one-to-clear
        wr(8'h04, 32'h0000_0001);
        rd(8'h04, 32'h0000_0004, "R4 clear bit0");
        check({31'b0, irq_o}, 1, "R6 irq holds");
        wr(8'h04, 32'h0000_0000);
        rd(8'h04, 32'h0000_0004, "R4 zero write no effect");
        wr(8'h04, 32'h0000_0004);
        rd(8'h04, 32'h0000_0000, "R4 clear bit2");
        check({31'b0, irq_o}, 0, "R6 irq dropped");

        // R5: set wins over clear in the same cycle
        wr(8'h08, 32'h0000_003F);
        pulse_evt(6'h08);
        rd(8'h04, 32'h0000_0008, "R5 ecc error latched");
        @(negedge clk);
        evt_i = 6'h08; bus_wr_en = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h08;
        @(negedge clk);
        evt_i = '0; bus_wr_en = 1'b0; bus_wdata = '0;
        rd(8'h04, 32'h0000_0008, "R5 set beats clear");
        @(negedge clk);
        evt_i = 6'h20; bus_wr_en = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h08;
        @(negedge clk);
        evt_i = '0; bus_wr_en = 1'b0; bus_wdata = '0;
        rd(8'h04, 32'h0000_0020, "R5 clear other bit same cycle");
        wr(8'h04, 32'h0000_003F);

        // R7: launch pulse while enabled
        wr(8'h40, 32'h8000_0002);
        check({31'b0, xfer_start_o}, 1, "R7 start pulse");
        check({31'b0, xfer_read_o}, 1, "R7 read direction");
        @(negedge clk);
        check({31'b0, xfer_start_o}, 0, "R7 pulse one cycle");
        rd(8'h40, 32'h0000_0002, "R7 go bit self-clears");
        wr(8'h40, 32'h6000_0000);
        check({31'b0, xfer_start_o}, 0, "R7 no go no pulse");
        check({30'b0, cont_sysm_o, cont_nand_o}, 32'h3, "R7 continuation outputs");
        rd(8'h40, 32'h6000_0000, "R7 continuation readback");

        // R8: launch ignored while disabled
        wr(8'h00, 32'h0000_0010);
        wr(8'h40, 32'h8000_0000);
        check({31'b0, xfer_start_o}, 0, "R8 disabled no pulse");
        @(negedge clk);
        check({31'b0, xfer_start_o}, 0, "R8 disabled no late pulse");
        rd(8'h40, 32'h0000_0000, "R8 dma readback");

        // R9: host configuration
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, 32'h0000_0035, "R9 host all ones");
        check({28'b0, mode_mapping_o, mode_mem2mem_o, layout_interleave_o, burst_incr_o},
              32'hF, "R9 host outputs");
        wr(8'h10, 32'h0000_0014);
        rd(8'h10, 32'h0000_0014, "R9 host m2m+interleave");

        // R10: plain registers, version, unmapped offset
        wr(8'h30, 32'h1234_5678);
        rd(8'h30, 32'h0000_0078, "R10 chunk count");
        wr(8'h44, 32'hDEAD_BEEF);
        wr(8'h48, 32'h0BAD_F00D);
        rd(8'h44, 32'hDEAD_BEEF, "R10 main addr");
        rd(8'h48, 32'h0BAD_F00D, "R10 spare addr");
        check(spare_addr_o, 32'h0BAD_F00D, "R10 spare addr output");
        rd(8'hD0, 32'h0003_0000, "R10 version");
        rd(8'h2C, 32'h0000_0000, "R10 unmapped");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R11 actual=%0d pending expected=0 pending", exp_q.size());
        end
        finish_run();
    end

endmodule